// File: doc/BRIEF.md
# Hot-Swap Bus Link Controller

This block decides when the card side of a two-wire clock/data bus may be joined to the backplane side after a card is plugged in or switched on. A live backplane may be in the middle of a transfer at that moment. Joining then would corrupt it, so the block watches the synchronised backplane clock and data lines. It closes the connect switch only once it has seen a stop condition or a quiet bus that has lasted long enough.

The enable input and the stuck-bus recovery request are synchronous to the block clock. When the link is joined, removing enable, or raising the recovery request, opens the switch in the same cycle with no qualification. After that the link must qualify again before it rejoins. The ready output models an open-drain status pin, active high here, and reports the joined state. The length of the quiet window is a parameter counted in timebase ticks, so one instance serves any clock rate.

Top module: `hsw_link_ctl`

## Requirements
- R1: After reset, and while reset is held, `link_close_o` and `ready_o` are 0.
- R2: With enable high and no recovery request, the switch never closes while backplane traffic contains neither a stop condition nor an unbroken quiet window.
- R3: A stop condition is a rise of data while clock was high on both the previous and the current synchronised sample. A stop closes the switch on the third rising clock edge after the data rise is applied at the input. Clock and data rising in the same cycle is not a stop.
- R4: The bus is quiet while both synchronised lines are high. After `IDLE_TICKS` timebase ticks of quiet, the switch closes. Any low sample on either line restarts the count. With a tick every cycle, the switch closes on edge `IDLE_TICKS+3` after both lines are released.
- R5: Driving enable low opens the switch in the same cycle (combinational path), and the link must qualify again before it rejoins.
- R6: A recovery request forces the switch open and ready low in the same cycle, even on a quiet bus. It also forces the link to qualify again.
- R7: `ready_o` equals `link_close_o` at every sample.
- R8: A stop condition that occurs while enable is low does not qualify a later join.
- R9: When enable becomes active (or the recovery request clears) on a bus that has already been quiet for the full window, the switch closes on the second rising edge.
- R10: The quiet window is counted in timebase ticks, not in clock cycles. With a tick every fourth cycle, no join occurs within `4*(IDLE_TICKS-1)` cycles of release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Request to join the two bus sides |
| recover_req_i | input | 1 | Stuck-bus recovery override, forces the link open |
| bp_scl_i | input | 1 | Sampled backplane clock line (asynchronous) |
| bp_sda_i | input | 1 | Sampled backplane data line (asynchronous) |
| tick_i | input | 1 | Timebase tick that advances the quiet-window count |
| link_close_o | output | 1 | Connect switch control, 1 = sides joined |
| ready_o | output | 1 | Joined status, active-high model of an open-drain pin |

## Verification
The bench targets the edges of qualification:
- A clock and data rise in the same cycle would join at once if taken for a stop.
- A quiet window broken by a single low clock cycle would join early if the counter did not restart.
- A stop seen while disabled would let the link splice into a later transfer if it were remembered.
- A tick-rate change would shorten the window if clock cycles were counted instead of ticks.

Random traffic that changes data only while clock is low shows that an active bus never joins. Exact-edge checks on stop and quiet joins expose any extra or missing pipeline stage. The bench also checks the same-cycle opening on enable loss and on a recovery request, which a registered path would delay by a cycle.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

   // Link controller states
   typedef enum logic [1:0] {
      LNK_OFF  = 2'd0,   // disabled or overridden, switch open
      LNK_WAIT = 2'd1,   // enabled, waiting for stop or quiet window
      LNK_ON   = 2'd2    // sides joined
   } lnk_state_e;

   // Index of each line inside the synchroniser vector
   localparam int unsigned LINE_SCL = 0;
   localparam int unsigned LINE_SDA = 1;
   localparam int unsigned LINE_CNT = 2;

endpackage

// File: rtl/hsw_sync.sv
module hsw_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hsw_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hsw_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q_o = stg[STAGES-1];

endmodule

// File: rtl/hsw_bus_watch.sv
module hsw_bus_watch #(
   parameter int unsigned IDLE_TICKS = 95,
   localparam int unsigned CNT_W     = $clog2(IDLE_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_s_i,
   input  logic             sda_s_i,
   input  logic             tick_i,
   output logic             stop_o,
   output logic             idle_full_o,
   output logic [CNT_W-1:0] idle_cnt_o
);

   localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(IDLE_TICKS);

   if (IDLE_TICKS < 1) begin : g_bad_idle
      $error("hsw_bus_watch: IDLE_TICKS must be at least 1");
   end

   logic             scl_q;
   logic             sda_q;
   logic [CNT_W-1:0] cnt_q;
   logic             quiet;

   // previous synchronised sample of each line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b0;
         sda_q <= 1'b0;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   // stop: data rises while clock is high on both samples
   assign stop_o = scl_s_i & scl_q & sda_s_i & ~sda_q;

   assign quiet = scl_s_i & sda_s_i;

   // quiet-window counter, saturating at the limit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!quiet) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != CNT_LIM)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign idle_full_o = (cnt_q == CNT_LIM);
   assign idle_cnt_o  = cnt_q;

endmodule

// File: rtl/hsw_link_fsm.sv
module hsw_link_fsm
   import hsw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic recover_i,
   input  logic stop_i,
   input  logic idle_full_i,
   output logic close_o
);

   lnk_state_e state_q;
   lnk_state_e state_d;
   logic       allowed;

   assign allowed = enable_i & ~recover_i;

   always_comb begin
      state_d = state_q;
      if (!allowed) begin
         state_d = LNK_OFF;
      end else begin
         unique case (state_q)
            LNK_OFF:  state_d = LNK_WAIT;
            LNK_WAIT: if (stop_i || idle_full_i) state_d = LNK_ON;
            LNK_ON:   state_d = LNK_ON;
            default:  state_d = LNK_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LNK_OFF;
      else        state_q <= state_d;
   end

   // opening is immediate: the switch is gated by the live permission
   assign close_o = (state_q == LNK_ON) & allowed;

endmodule

// File: rtl/hsw_link_ctl.sv
module hsw_link_ctl
   import hsw_pkg::*;
#(
   parameter int unsigned IDLE_TICKS  = 95,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  logic recover_req_i,
   input  logic bp_scl_i,
   input  logic bp_sda_i,
   input  logic tick_i,
   output logic link_close_o,
   output logic ready_o
);

   localparam int unsigned CNT_W = $clog2(IDLE_TICKS + 1);

   if (IDLE_TICKS < 1) begin : g_bad_idle
      $error("hsw_link_ctl: IDLE_TICKS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("hsw_link_ctl: SYNC_STAGES must be at least 2");
   end

   logic [LINE_CNT-1:0] lines_raw;
   logic [LINE_CNT-1:0] lines_s;
   logic                scl_s;
   logic                sda_s;
   logic                stop_pulse;
   logic                idle_full;
   logic [CNT_W-1:0]    idle_cnt;
   logic                close;

   assign lines_raw[LINE_SCL] = bp_scl_i;
   assign lines_raw[LINE_SDA] = bp_sda_i;

   hsw_sync #(
      .WIDTH  (LINE_CNT),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (lines_raw),
      .q_o   (lines_s)
   );

   assign scl_s = lines_s[LINE_SCL];
   assign sda_s = lines_s[LINE_SDA];

   hsw_bus_watch #(
      .IDLE_TICKS (IDLE_TICKS)
   ) u_watch (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_s_i     (scl_s),
      .sda_s_i     (sda_s),
      .tick_i      (tick_i),
      .stop_o      (stop_pulse),
      .idle_full_o (idle_full),
      .idle_cnt_o  (idle_cnt)
   );

   hsw_link_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .enable_i    (enable_i),
      .recover_i   (recover_req_i),
      .stop_i      (stop_pulse),
      .idle_full_i (idle_full),
      .close_o     (close)
   );

   assign link_close_o = close;
   assign ready_o      = close;

endmodule

// File: rtl/hsw_link_ctl_chk.sv
module hsw_link_ctl_chk #(
   parameter int unsigned IDLE_TICKS = 95,
   localparam int unsigned CNT_W     = $clog2(IDLE_TICKS + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable_i,
   input logic             recover_i,
   input logic             close_o,
   input logic             ready_o,
   input logic             scl_s,
   input logic             sda_s,
   input logic             stop_p,
   input logic             idle_full,
   input logic [CNT_W-1:0] idle_cnt
);

   // R5: no enable, no connection
   a_r5_enable_low_open: assert property (@(posedge clk) disable iff (!rst_n)
      !enable_i |-> !close_o);

   // R6: recovery request keeps ready low
   a_r6_recover_open: assert property (@(posedge clk) disable iff (!rst_n)
      recover_i |-> !ready_o);

   // R2: a new join is preceded by a stop or a full quiet window
   a_r2_join_qualified: assert property (@(posedge clk) disable iff (!rst_n)
      (close_o && !$past(close_o)) |-> $past(stop_p || idle_full));

   // R4: any low sample clears the quiet count
   a_r4_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_s && sda_s) |=> (idle_cnt == '0));

   // R4: the count never passes the window length
   a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      idle_cnt <= CNT_W'(IDLE_TICKS));

endmodule

bind hsw_link_ctl hsw_link_ctl_chk #(
   .IDLE_TICKS (IDLE_TICKS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable_i  (enable_i),
   .recover_i (recover_req_i),
   .close_o   (link_close_o),
   .ready_o   (ready_o),
   .scl_s     (scl_s),
   .sda_s     (sda_s),
   .stop_p    (stop_pulse),
   .idle_full (idle_full),
   .idle_cnt  (idle_cnt)
);

// File: tb/hsw_link_ctl_tb_top.sv
module hsw_link_ctl_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_IDLE     = 12;

   logic clk = 1'b0;
   logic rst_n;
   logic enable;
   logic recover;
   logic scl;
   logic sda;
   logic tick;
   logic link_close_o;
   logic ready_o;

   int   tick_div = 1;
   int   tick_cnt = 0;
   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hsw_link_ctl #(
      .IDLE_TICKS  (N_IDLE),
      .SYNC_STAGES (2)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable_i      (enable),
      .recover_req_i (recover),
      .bp_scl_i      (scl),
      .bp_sda_i      (sda),
      .tick_i        (tick),
      .link_close_o  (link_close_o),
      .ready_o       (ready_o)
   );

   // timebase: one tick every tick_div cycles, changed at the falling edge
   always @(negedge clk) begin
      if (tick_cnt + 1 >= tick_div) begin
         tick     <= 1'b1;
         tick_cnt <= 0;
      end else begin
         tick     <= 1'b0;
         tick_cnt <= tick_cnt + 1;
      end
   end

   task automatic chk_link(input string req, input logic exp);
      n_checks++;
      if (link_close_o !== exp) begin
         n_fail++;
         $display("FAIL %s: link_close_o=%0b expected %0b at %0t", req, link_close_o, exp, $time);
      end
      // R7: ready mirrors the switch
      n_checks++;
      if (ready_o !== exp) begin
         n_fail++;
         $display("FAIL R7 (%s): ready_o=%0b expected %0b at %0t", req, ready_o, exp, $time);
      end
   endtask

   // random bus traffic: data changes only while clock is low,
   // clock never high for more than 4 cycles, so no stop and no quiet window
   task automatic traffic(input int n, output bit joined);
      int hi_run = 0;
      joined = 1'b0;
      scl = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (link_close_o) joined = 1'b1;
         if (scl == 1'b0) begin
            if ($urandom_range(1, 0) == 1) sda = 1'($urandom_range(1, 0));
            if ($urandom_range(2, 0) != 0) begin
               scl    = 1'b1;
               hi_run = 0;
            end
         end else begin
            hi_run++;
            if (hi_run >= 4 || $urandom_range(1, 0) == 1) scl = 1'b0;
         end
      end
   endtask

   // ends at the falling edge where data rises with clock long high
   task automatic make_stop();
      scl = 1'b0;
      @(negedge clk); sda = 1'b0;
      @(negedge clk); scl = 1'b1;
      repeat (3) @(negedge clk);
      sda = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
   end

   initial begin
      bit j;
      void'($urandom(32'd7331));
      rst_n   = 1'b0;
      enable  = 1'b0;
      recover = 1'b0;
      scl     = 1'b1;
      sda     = 1'b1;
      repeat (3) @(negedge clk);
      chk_link("R1 in reset", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_link("R1 after reset", 1'b0);

      // R2: enabled, random traffic segments, never joins
      traffic(20, j);
      enable = 1'b1;
      for (int s = 0; s < 3; s++) begin
         traffic(int'($urandom_range(120, 40)), j);
         n_checks++;
         if (j) begin
            n_fail++;
            $display("FAIL R2: joined during traffic got 1 expected 0");
         end
      end

      // R3: stop joins on the third edge
      make_stop();
      repeat (2) @(negedge clk);
      chk_link("R3 stop edge 2", 1'b0);
      @(negedge clk);
      chk_link("R3 stop edge 3", 1'b1);

      // R5: enable low opens in the same cycle, then must requalify
      enable = 1'b0;
      #1;
      chk_link("R5 same cycle open", 1'b0);
      traffic(10, j);
      enable = 1'b1;
      traffic(50, j);
      chk_link("R5 requalify", 1'b0);

      // R4: quiet window from a simultaneous release (also not a stop, R3)
      scl = 1'b0; sda = 1'b0;
      @(negedge clk);
      scl = 1'b1; sda = 1'b1;
      repeat (3) @(negedge clk);
      chk_link("R3 simultaneous rise", 1'b0);
      repeat (N_IDLE + 2 - 3) @(negedge clk);
      chk_link("R4 window edge N+2", 1'b0);
      @(negedge clk);
      chk_link("R4 window edge N+3", 1'b1);

      // R6: recovery forces open, even on a quiet bus
      recover = 1'b1;
      #1;
      chk_link("R6 same cycle open", 1'b0);
      repeat (20) @(negedge clk);
      chk_link("R6 held on quiet bus", 1'b0);
      // R9: release on an already quiet bus joins on edge 2
      recover = 1'b0;
      @(negedge clk);
      chk_link("R9 edge 1", 1'b0);
      @(negedge clk);
      chk_link("R9 edge 2", 1'b1);

      // R8: stop while disabled is not remembered
      enable = 1'b0;
      traffic(10, j);
      make_stop();
      repeat (4) @(negedge clk);
      enable = 1'b1;
      traffic(60, j);
      n_checks++;
      if (j) begin
         n_fail++;
         $display("FAIL R8: joined after disabled stop got 1 expected 0");
      end

      // R4: single low clock cycle restarts the window
      traffic(30, j);
      scl = 1'b0; sda = 1'b0;
      @(negedge clk);
      scl = 1'b1; sda = 1'b1;
      repeat (N_IDLE - 3) @(negedge clk);
      scl = 1'b0;
      @(negedge clk);
      scl = 1'b1;
      repeat (N_IDLE + 2) @(negedge clk);
      chk_link("R4 restart edge N+2", 1'b0);
      @(negedge clk);
      chk_link("R4 restart edge N+3", 1'b1);

      // R10: window counted in ticks
      enable = 1'b0;
      traffic(10, j);
      enable = 1'b1;
      traffic(30, j);
      tick_div = 4;
      scl = 1'b0; sda = 1'b0;
      @(negedge clk);
      scl = 1'b1; sda = 1'b1;
      repeat (4 * (N_IDLE - 1)) @(negedge clk);
      chk_link("R10 before window", 1'b0);
      repeat (10) @(negedge clk);
      chk_link("R10 after window", 1'b1);
      tick_div = 1;

      // R1: reset while joined
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk_link("R1 reset while joined", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_link("R1 after second reset", 1'b0);

      finish_run();
   end

endmodule